// File: doc/BRIEF.md
# Multiphase Rail Fault Shutdown Sequencer

This block forces the switching outputs of a multiphase power stage into their disabled state when a fault is seen. Each phase has an external fault input, and each voltage rail has one current-sense comparator fault flag. A static map assigns every phase to a rail. The block runs on its own and does not depend on any slow monitoring loop.

A fault on a phase's pin disables that phase's PWM and synchronous-rectifier outputs on the next clock. A comparator fault acts on the whole rail. First it waits for the next switching-cycle boundary of the rail's lowest-numbered phase, or for a timeout if the strobes have stopped, and disables that phase. It then walks the remaining phase indices in ascending order, one per clock, and disables each phase that belongs to the rail. Disabled outputs stay latched, as do per-rail status bits that record which path caused the shutdown. Only a clear pulse, given while everything is quiet, releases them.

Top module: `rail_fault_shutdown`

## Requirements
- R1: When `fault_pin[p]` is high at a rising clock edge, `pwm_dis[p]` and `sr_dis[p]` are high from that edge on. Other phases are not affected.
- R2: When `fault_pin[p]` is high at an edge, the `pin_status` bit of the rail mapped to phase p is set at that edge. The rail of phase p is the field `phase_rail[p*RAIL_W +: RAIL_W]`.
- R3: When `cmp_fault[r]` is high at an edge while rail r is idle, `cmp_status[r]` is set and the rail arms. The rail does not act on a `sw_strobe` that is high at that same edge. While armed, a `sw_strobe` of the rail's lowest-indexed member phase disables that phase at that edge. Strobes of any other phase have no effect.
- R4: When an armed rail sees no qualifying strobe, the first phase is disabled ARM_TIMEOUT edges after the rail armed (default 8).
- R5: After the first phase is disabled, each higher-indexed member phase q is disabled exactly (q − first) clocks later. The whole rail is therefore disabled within NUM_PHASES clocks of the first.
- R6: A comparator fault never disables a phase mapped to a different rail.
- R7: A comparator fault on a rail with no member phases sets its `cmp_status` bit and disables no output.
- R8: Disabled outputs and status bits stay set until a clear takes effect.
- R9: A `fault_clr` pulse clears all outputs and status bits at that edge, but only when no `fault_pin` and no `cmp_fault` is high and no rail is armed or walking. Otherwise the pulse is ignored.
- R10: A pin fault and a comparator walk that land on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_pin | input | NUM_PHASES | Per-phase external fault, active high |
| cmp_fault | input | NUM_RAILS | Per-rail current comparator fault flag |
| sw_strobe | input | NUM_PHASES | Per-phase switching-cycle boundary strobe |
| phase_rail | input | NUM_PHASES*RAIL_W | Rail index of each phase, field p at [p*RAIL_W +: RAIL_W] |
| fault_clr | input | 1 | Clear request for latched shutdown |
| pwm_dis | output | NUM_PHASES | Per-phase PWM disable |
| sr_dis | output | NUM_PHASES | Per-phase synchronous-rectifier disable |
| pin_status | output | NUM_RAILS | Sticky: rail shut down by a fault pin |
| cmp_status | output | NUM_RAILS | Sticky: rail shut down by its comparator |

## Verification
A pin fault on one phase can arrive on the same edge at which a comparator walk disables another phase of the same rail. To provoke this, the bench raises the pin of a non-member phase one clock before the walk reaches the next member. It then expects both bits to appear together, with both status bits set. A clear pulse arriving while a comparator is still high, or while a fault pin is high, is also judged: every output must remain set.

// File: rtl/rail_fault_shutdown.sv
module rail_fault_shutdown #(
  parameter int NUM_PHASES  = 4,
  parameter int NUM_RAILS   = 2,
  parameter int ARM_TIMEOUT = 8,
  parameter int RAIL_W      = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PHASES-1:0]        fault_pin,
  input  logic [NUM_RAILS-1:0]         cmp_fault,
  input  logic [NUM_PHASES-1:0]        sw_strobe,
  input  logic [NUM_PHASES*RAIL_W-1:0] phase_rail,
  input  logic                         fault_clr,
  output logic [NUM_PHASES-1:0]        pwm_dis,
  output logic [NUM_PHASES-1:0]        sr_dis,
  output logic [NUM_RAILS-1:0]         pin_status,
  output logic [NUM_RAILS-1:0]         cmp_status
);
  localparam int PW = (NUM_PHASES > 1) ? $clog2(NUM_PHASES) : 1;
  localparam int TW = $clog2(ARM_TIMEOUT + 1);
  localparam int KW = $clog2(NUM_PHASES + 1);

  typedef enum logic [1:0] {RS_IDLE, RS_ARM, RS_WALK, RS_DONE} rail_st_t;

  logic [RAIL_W-1:0] rail_of [NUM_PHASES];
  rail_st_t          st      [NUM_RAILS];
  logic [PW-1:0]     ptr     [NUM_RAILS];
  logic [TW-1:0]     wcnt    [NUM_RAILS];
  logic [PW-1:0]     first   [NUM_RAILS];
  logic [NUM_RAILS-1:0] has_member, fire, busy_r;
  logic [NUM_PHASES-1:0] set_mask;
  logic busy, clr_ok;

  genvar gp;
  generate
    for (gp = 0; gp < NUM_PHASES; gp++) begin : g_map
      assign rail_of[gp] = phase_rail[gp*RAIL_W +: RAIL_W];
    end
  endgenerate

  always_comb begin
    for (int r = 0; r < NUM_RAILS; r++) begin
      first[r]      = '0;
      has_member[r] = 1'b0;
      for (int p = NUM_PHASES - 1; p >= 0; p--) begin
        if (rail_of[p] == RAIL_W'(r)) begin
          first[r]      = PW'(p);
          has_member[r] = 1'b1;
        end
      end
      fire[r]   = (st[r] == RS_ARM) &&
                  (sw_strobe[first[r]] || wcnt[r] == TW'(ARM_TIMEOUT - 1));
      busy_r[r] = (st[r] == RS_ARM) || (st[r] == RS_WALK);
    end
  end

  assign busy   = |busy_r;
  assign clr_ok = fault_clr && !(|fault_pin) && !(|cmp_fault) && !busy;

  always_comb begin
    set_mask = fault_pin;
    for (int r = 0; r < NUM_RAILS; r++) begin
      if (fire[r]) set_mask[first[r]] = 1'b1;
      if (st[r] == RS_WALK && rail_of[ptr[r]] == RAIL_W'(r)) set_mask[ptr[r]] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_dis <= '0;
      sr_dis  <= '0;
    end else if (clr_ok) begin
      pwm_dis <= '0;
      sr_dis  <= '0;
    end else begin
      pwm_dis <= pwm_dis | set_mask;
      sr_dis  <= sr_dis  | set_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_status <= '0;
    end else if (clr_ok) begin
      pin_status <= '0;
    end else begin
      for (int p = 0; p < NUM_PHASES; p++)
        if (fault_pin[p] && int'(rail_of[p]) < NUM_RAILS) pin_status[rail_of[p]] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_status <= '0;
      for (int r = 0; r < NUM_RAILS; r++) begin
        st[r]   <= RS_IDLE;
        ptr[r]  <= '0;
        wcnt[r] <= '0;
      end
    end else if (clr_ok) begin
      cmp_status <= '0;
      for (int r = 0; r < NUM_RAILS; r++) begin
        st[r]   <= RS_IDLE;
        ptr[r]  <= '0;
        wcnt[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NUM_RAILS; r++) begin
        case (st[r])
          RS_IDLE: if (cmp_fault[r]) begin
            cmp_status[r] <= 1'b1;
            wcnt[r]       <= '0;
            st[r]         <= has_member[r] ? RS_ARM : RS_DONE;
          end
          RS_ARM: if (fire[r]) begin
            ptr[r] <= first[r] + PW'(1);
            st[r]  <= (first[r] == PW'(NUM_PHASES - 1)) ? RS_DONE : RS_WALK;
          end else begin
            wcnt[r] <= wcnt[r] + TW'(1);
          end
          RS_WALK: if (ptr[r] == PW'(NUM_PHASES - 1)) st[r] <= RS_DONE;
                   else ptr[r] <= ptr[r] + PW'(1);
          default: st[r] <= RS_DONE;
        endcase
      end
    end
  end

  // Checks kept beside the logic they guard.
  logic [KW-1:0] walk_len [NUM_RAILS];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int r = 0; r < NUM_RAILS; r++) walk_len[r] <= '0;
    else for (int r = 0; r < NUM_RAILS; r++)
      walk_len[r] <= (st[r] == RS_WALK) ? walk_len[r] + KW'(1) : '0;
  end

  generate
    for (gp = 0; gp < NUM_PHASES; gp++) begin : g_pa
      p_pin_disables_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pin[gp] |=> (pwm_dis[gp] && sr_dis[gp]));
      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_dis[gp] && !fault_clr) |=> pwm_dis[gp]);
      for (genvar gr = 0; gr < NUM_RAILS; gr++) begin : g_pr
        p_pin_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
          (fault_pin[gp] && rail_of[gp] == RAIL_W'(gr)) |=> pin_status[gr]);
      end
    end
    for (genvar gr = 0; gr < NUM_RAILS; gr++) begin : g_ra
      p_cmp_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_fault[gr] |=> cmp_status[gr]);
      p_walk_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        walk_len[gr] < KW'(NUM_PHASES));
    end
  endgenerate

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok |=> (pwm_dis == '0 && sr_dis == '0 && pin_status == '0 && cmp_status == '0));
endmodule

// File: tb/sim_rail_fault_shutdown.sv
`timescale 1ns/1ps
module sim_rail_fault_shutdown;
  logic clk = 1'b0, rst_n = 1'b0, fault_clr = 1'b0;
  logic [3:0] fault_pin = '0, sw_strobe = '0, pwm_dis, sr_dis;
  logic [1:0] cmp_fault = '0, pin_status, cmp_status;
  logic [3:0] phase_rail = 4'b0010;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rail_fault_shutdown u0 (
    .clk(clk), .rst_n(rst_n), .fault_pin(fault_pin), .cmp_fault(cmp_fault),
    .sw_strobe(sw_strobe), .phase_rail(phase_rail), .fault_clr(fault_clr),
    .pwm_dis(pwm_dis), .sr_dis(sr_dis), .pin_status(pin_status), .cmp_status(cmp_status));

  // {pins[3:0], expected pin_status[1:0]} with phase1 on rail1, others rail0
  localparam logic [5:0] VEC [6] = '{
    {4'b0001, 2'b01}, {4'b0010, 2'b10}, {4'b1000, 2'b01},
    {4'b0110, 2'b11}, {4'b1111, 2'b11}, {4'b0000, 2'b00}};

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_clear();
    fault_clr = 1'b1; tick(); fault_clr = 1'b0;
    chk("R9 clear", {pwm_dis, sr_dis, pin_status, cmp_status}, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R8 reset state", {pwm_dis, sr_dis, pin_status, cmp_status}, 0);
    rst_n = 1'b1; tick();

    for (int i = 0; i < 6; i++) begin
      fault_pin = VEC[i][5:2]; tick(); fault_pin = '0;
      chk("R1 pwm", pwm_dis, VEC[i][5:2]);
      chk("R1 sr", sr_dis, VEC[i][5:2]);
      chk("R2 pin status", pin_status, VEC[i][1:0]);
      chk("R6 no cmp status", cmp_status, 0);
      do_clear();
    end

    // comparator on rail0 with strobe, pin fault landing on a walk edge
    cmp_fault = 2'b01; sw_strobe = 4'b0001; tick();
    sw_strobe = '0;
    chk("R3 arm status", cmp_status, 2'b01);
    chk("R3 strobe on arming edge ignored", pwm_dis, 0);
    sw_strobe = 4'b0001; tick(); sw_strobe = '0;
    chk("R3 first phase", pwm_dis, 4'b0001);
    tick();
    chk("R5 non-member skipped", pwm_dis, 4'b0001);
    fault_pin = 4'b0010; tick(); fault_pin = '0;
    chk("R10 coincident pwm", pwm_dis, 4'b0111);
    chk("R10 coincident sr", sr_dis, 4'b0111);
    chk("R10 both status", {pin_status, cmp_status}, 4'b1001);
    tick();
    chk("R5 last member", pwm_dis, 4'b1111);
    fault_clr = 1'b1; tick(); fault_clr = 1'b0;
    chk("R9 clear ignored while comparator high", pwm_dis, 4'b1111);
    cmp_fault = '0; tick();
    chk("R8 held", {pwm_dis, cmp_status}, {4'b1111, 2'b01});
    do_clear();

    // timeout path, other phases strobing
    cmp_fault = 2'b01; tick(); cmp_fault = '0;
    sw_strobe = 4'b1110;
    repeat (7) tick();
    chk("R4 not before timeout", pwm_dis, 0);
    chk("R3 other strobes no effect", sr_dis, 0);
    fault_clr = 1'b1; tick(); fault_clr = 1'b0;
    chk("R4 timeout first phase", pwm_dis, 4'b0001);
    chk("R9 clear ignored while armed", cmp_status, 2'b01);
    repeat (3) tick(); sw_strobe = '0;
    chk("R6 rail0 walk leaves phase1", pwm_dis, 4'b1101);
    do_clear();

    // single-member rail1
    cmp_fault = 2'b10; tick(); cmp_fault = '0;
    sw_strobe = 4'b0010; tick(); sw_strobe = '0;
    chk("R3 rail1 first", pwm_dis, 4'b0010);
    repeat (4) tick();
    chk("R6 rail1 only", {pwm_dis, cmp_status}, {4'b0010, 2'b10});
    do_clear();

    // empty rail
    phase_rail = 4'b0000;
    cmp_fault = 2'b10; tick();
    chk("R7 status set", cmp_status, 2'b10);
    repeat (10) tick();
    chk("R7 no outputs", {pwm_dis, sr_dis}, 0);
    cmp_fault = '0; tick();
    do_clear();

    // clear with a pin active
    fault_pin = 4'b0100; fault_clr = 1'b1; tick(); fault_clr = 1'b0; fault_pin = '0;
    chk("R9 clear ignored while pin high", {pwm_dis, pin_status}, {4'b0100, 2'b01});
    do_clear();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule